// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Register Front End

This block holds the digital codes for a four-channel, 8-bit converter. A host drives a shared 8-bit data bus, a 2-bit channel address and two active-low strobes: a write strobe that loads one channel's staging register, and a load strobe that all four channels share and that copies every staging register into the matching output register. Only the output registers set the channel codes, so the four channels can be staged one by one and then changed at the same moment.

The host pins are asynchronous to the system clock. Each pin passes through a two-stage synchronizer. Transparency is modelled by rewriting a register on every clock cycle while its strobe is low, so the value held when the strobe returns high is the last bus value sampled before that edge. When both strobes are low, the addressed channel's output follows the bus with no added cycle. The block also checks a timing rule: when the load strobe goes low before the write strobe rises, it must stay low for a minimum hold window after the write strobe rises. A one-cycle flag reports any load that ends inside that window. A second one-cycle flag marks every cycle in which any output code changes. Codes are straight binary, and the ideal channel level is code/256 of that channel's reference.

Top module: `quad_dac_regif`

## Requirements
- R1: While rst_ni is low, all staging and output registers clear to 0, and both flags read 0.
- R2: Address 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel k occupies bits [8k+7:8k] of dac_code_o.
- R3: While wr_ni is low, only the addressed staging register follows data_i. It keeps the last sampled value after wr_ni rises. The other staging registers do not change.
- R4: While ld_ni is low, all four output registers take their staging values in the same clock cycle. They keep those values after ld_ni rises.
- R5: When wr_ni and ld_ni are both high, no register changes, whatever data_i and addr_i do.
- R6: When wr_ni and ld_ni are both low, the addressed channel's output follows data_i.
- R7: A write made while ld_ni is high leaves every output code unchanged until a load.
- R8: When ld_ni is low in the cycle before wr_ni rises, and ld_ni then rises fewer than HOLD_CYC synchronized cycles after that rise (HOLD_CYC = ceil(HOLD_PS/CLK_PS), 12 by default, a simultaneous rise included), hold_err_o pulses high for one cycle. A load that ends at or after HOLD_CYC cycles, or a load with no write pending, gives no pulse.
- R9: upd_o is high in exactly those cycles in which dac_code_o differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 8 | Shared code bus |
| addr_i | input | 2 | Channel select for writes |
| wr_ni | input | 1 | Active-low write strobe |
| ld_ni | input | 1 | Active-low load strobe, shared by all channels |
| dac_code_o | output | 32 | Four output codes, channel A in the low byte |
| upd_o | output | 1 | High in a cycle in which any output code changed |
| hold_err_o | output | 1 | One-cycle pulse when the load hold window is cut short |

## Verification
The bench writes every code to every channel and then loads it. A broken address decode would put the code on the wrong byte lane, and a missing double buffer would move an output before the load. It stages four distinct codes and then issues one load, expecting all lanes to change with a single update pulse; a per-channel transfer would give staggered lanes or extra pulses. It holds both strobes low while it walks the bus, to catch an output that lags the bus by a cycle. It sweeps the load release around the hold window: released together with the write, inside the window, and at exactly HOLD_CYC. An off-by-one counter would fail the boundary case, and a flag with no arming logic would fire on a plain load.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int DEF_CODE_W = 8;
  localparam int DEF_CH_N   = 4;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dac_in_bank.sv
module dac_in_bank #(
  parameter int CH_N   = 4,
  parameter int CODE_W = 8,
  localparam int AW    = $clog2(CH_N),
  localparam int BUS_W = CH_N * CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_low_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [BUS_W-1:0]  in_nxt_o,
  output logic [BUS_W-1:0]  in_q_o
);
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic sel;
    assign sel = wr_low_i && (addr_i == AW'(c));
    assign in_nxt_o[c*CODE_W +: CODE_W] = sel ? data_i : in_q_o[c*CODE_W +: CODE_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) in_q_o[c*CODE_W +: CODE_W] <= '0;
      else         in_q_o[c*CODE_W +: CODE_W] <= in_nxt_o[c*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/dac_out_bank.sv
module dac_out_bank #(
  parameter int CH_N   = 4,
  parameter int CODE_W = 8,
  localparam int BUS_W = CH_N * CODE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_low_i,
  input  logic [BUS_W-1:0] src_i,
  output logic [BUS_W-1:0] dac_q_o,
  output logic             upd_o
);
  logic [BUS_W-1:0] dac_nxt;
  logic [CH_N-1:0]  lane_chg;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    assign dac_nxt[c*CODE_W +: CODE_W] = ld_low_i ? src_i[c*CODE_W +: CODE_W]
                                                  : dac_q_o[c*CODE_W +: CODE_W];
    assign lane_chg[c] = dac_nxt[c*CODE_W +: CODE_W] != dac_q_o[c*CODE_W +: CODE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q_o <= '0;
      upd_o   <= 1'b0;
    end else begin
      dac_q_o <= dac_nxt;
      upd_o   <= |lane_chg;
    end
  end
endmodule

// File: rtl/dac_hold_mon.sv
module dac_hold_mon #(
  parameter int HOLD_CYC = 12,
  localparam int CW      = $clog2(HOLD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_s_i,
  input  logic ld_s_i,
  output logic err_o
);
  logic          wr_d, ld_d, armed;
  logic [CW-1:0] cnt;
  logic          wr_rise, ld_rise, early;

  assign wr_rise = wr_s_i && !wr_d;
  assign ld_rise = ld_s_i && !ld_d;
  // a load ending with the write edge, or inside the window, is early
  assign early   = ld_rise && ((wr_rise && !ld_d) || (armed && cnt < CW'(HOLD_CYC)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_d  <= 1'b1;
      ld_d  <= 1'b1;
      armed <= 1'b0;
      cnt   <= '0;
      err_o <= 1'b0;
    end else begin
      wr_d  <= wr_s_i;
      ld_d  <= ld_s_i;
      err_o <= early;
      if (wr_rise && !ld_d && !ld_s_i) begin
        armed <= 1'b1;
        cnt   <= CW'(1);
      end else if (armed) begin
        if (ld_rise || cnt >= CW'(HOLD_CYC)) armed <= 1'b0;
        else cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
  import quad_dac_pkg::*;
#(
  parameter int CH_N    = DEF_CH_N,
  parameter int CODE_W  = DEF_CODE_W,
  parameter int CLK_PS  = 8000,
  parameter int HOLD_PS = 95000,
  localparam int AW       = $clog2(CH_N),
  localparam int BUS_W    = CH_N * CODE_W,
  localparam int HOLD_CYC = ceil_div(HOLD_PS, CLK_PS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] data_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_ni,
  input  logic              ld_ni,
  output logic [BUS_W-1:0]  dac_code_o,
  output logic              upd_o,
  output logic              hold_err_o
);
  localparam int SW = CODE_W + AW + 2;

  logic [SW-1:0]     pins, pins_s;
  logic              wr_s, ld_s;
  logic [AW-1:0]     addr_s;
  logic [CODE_W-1:0] data_s;
  logic [BUS_W-1:0]  in_nxt, in_q;

  assign pins = {wr_ni, ld_ni, addr_i, data_i};

  dac_sync #(.W(SW), .STAGES(2), .RST_VAL({2'b11, {(SW-2){1'b0}}})) u_sync (
    .clk_i, .rst_ni, .d_i(pins), .q_o(pins_s)
  );

  assign {wr_s, ld_s, addr_s, data_s} = pins_s;

  dac_in_bank #(.CH_N(CH_N), .CODE_W(CODE_W)) u_in (
    .clk_i, .rst_ni, .wr_low_i(!wr_s), .addr_i(addr_s), .data_i(data_s),
    .in_nxt_o(in_nxt), .in_q_o(in_q)
  );

  // output bank sees next staging value, so both-low is a flow-through path
  dac_out_bank #(.CH_N(CH_N), .CODE_W(CODE_W)) u_out (
    .clk_i, .rst_ni, .ld_low_i(!ld_s), .src_i(in_nxt),
    .dac_q_o(dac_code_o), .upd_o(upd_o)
  );

  dac_hold_mon #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i, .rst_ni, .wr_s_i(wr_s), .ld_s_i(ld_s), .err_o(hold_err_o)
  );
endmodule

// File: rtl/quad_dac_regif_chk.sv
module quad_dac_regif_chk #(
  parameter int CH_N   = 4,
  parameter int CODE_W = 8,
  localparam int BUS_W = CH_N * CODE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_s,
  input logic             ld_s,
  input logic [BUS_W-1:0] in_q,
  input logic [BUS_W-1:0] dac_code_o,
  input logic             upd_o,
  input logic             hold_err_o
);
  logic [1:0]       age;
  logic             vld;
  logic [BUS_W-1:0] in_prev;
  logic [CH_N-1:0]  in_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age     <= '0;
      in_prev <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      in_prev <= in_q;
    end
  end
  assign vld = (age == 2'd3);

  for (genvar c = 0; c < CH_N; c++) begin : g_chg
    assign in_chg[c] = in_q[c*CODE_W +: CODE_W] != in_prev[c*CODE_W +: CODE_W];
  end

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (dac_code_o == '0 && !upd_o && !hold_err_o) || !rst_ni);

  assert_single_stage_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld |-> $countones(in_chg) <= 1);

  assert_stage_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld && wr_s |=> $stable(in_q));

  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld && wr_s && ld_s |=> $stable(in_q) && $stable(dac_code_o));

  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld && ld_s |=> $stable(dac_code_o));

  assert_upd_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld |-> (upd_o == (dac_code_o != $past(dac_code_o))));

  assert_err_on_load_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld && hold_err_o |-> $past(ld_s) && !$past(ld_s, 2));
endmodule

bind quad_dac_regif quad_dac_regif_chk #(.CH_N(CH_N), .CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_s(wr_s), .ld_s(ld_s), .in_q(in_q),
  .dac_code_o(dac_code_o), .upd_o(upd_o), .hold_err_o(hold_err_o)
);

// File: tb/tb_quad_dac_regif.sv
module tb_quad_dac_regif;
  localparam int HOLD = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data = '0;
  logic [1:0]  addr = '0;
  logic        wr_n = 1'b1, ld_n = 1'b1;
  logic [31:0] dac;
  logic        upd, herr;

  int checks = 0, errors = 0;
  int upd_cnt = 0, err_cnt = 0;
  logic [7:0] exp_in [4];
  logic [7:0] exp_dac [4];

  always #4 clk = ~clk;

  quad_dac_regif dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data), .addr_i(addr),
    .wr_ni(wr_n), .ld_ni(ld_n), .dac_code_o(dac), .upd_o(upd), .hold_err_o(herr)
  );

  always @(negedge clk) begin
    if (upd)  upd_cnt++;
    if (herr) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_lanes(input string req);
    for (int c = 0; c < 4; c++)
      chk(dac[c*8 +: 8] == exp_dac[c], req, dac[c*8 +: 8], exp_dac[c]);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; data = d; wr_n = 1'b0;
    wait_n(2);
    wr_n = 1'b1;
    wait_n(4);
    exp_in[a] = d;
    if (!ld_n) exp_dac[a] = d;
  endtask

  task automatic do_load();
    ld_n = 1'b0;
    wait_n(2);
    ld_n = 1'b1;
    wait_n(4);
    for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
  endtask

  // ld low first, write, then release ld k cycles after wr rises
  task automatic hold_case(input int k, input logic [7:0] d, input int exp_err);
    int e0;
    e0 = err_cnt;
    ld_n = 1'b0;
    wait_n(3);
    addr = 2'd1; data = d; wr_n = 1'b0;
    wait_n(2);
    wr_n = 1'b1;
    if (k > 0) wait_n(k);
    ld_n = 1'b1;
    wait_n(HOLD + 6);
    exp_in[1] = d;
    for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
    chk(err_cnt - e0 == exp_err, $sformatf("R8 k=%0d", k), err_cnt - e0, exp_err);
    chk(dac[15:8] == d, "R8 data landed", dac[15:8], d);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin exp_in[c] = '0; exp_dac[c] = '0; end
    wait_n(3);
    // R1 reset state
    chk(dac == '0, "R1 codes", dac, 0);
    chk(!upd && !herr, "R1 flags", {upd, herr}, 0);
    rst_ni = 1'b1;
    wait_n(3);
    chk(dac == '0, "R1 after release", dac, 0);

    // R2 R7 R4 R9 sweep of every code on every channel
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] code;
        int u0;
        bit changed;
        code = 8'(v ^ (c * 37));
        do_write(2'(c), code);
        if (v % 64 == 0) chk_lanes("R7 no move before load");
        changed = exp_dac[c] != code;
        u0 = upd_cnt;
        do_load();
        chk(dac[c*8 +: 8] == code, "R2 lane", dac[c*8 +: 8], code);
        if (v % 32 == 0) chk_lanes("R2 other lanes");
        chk(upd_cnt - u0 == int'(changed), "R9 pulse count", upd_cnt - u0, int'(changed));
      end
    end

    // R4 simultaneous update of four staged codes
    begin
      int u0;
      do_write(2'd0, 8'h11); do_write(2'd1, 8'h22);
      do_write(2'd2, 8'h33); do_write(2'd3, 8'h44);
      chk_lanes("R7 staged only");
      u0 = upd_cnt;
      ld_n = 1'b0;
      wait_n(3);
      chk(dac == 32'h44332211, "R4 all lanes together", dac, 32'h44332211);
      ld_n = 1'b1;
      wait_n(4);
      for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
      chk(upd_cnt - u0 == 1, "R4 R9 one pulse", upd_cnt - u0, 1);
    end

    // R5 bus activity with both strobes high
    begin
      int u0;
      u0 = upd_cnt;
      for (int i = 0; i < 8; i++) begin
        addr = 2'(i); data = 8'(i * 29 + 5);
        wait_n(2);
      end
      wait_n(4);
      chk_lanes("R5 idle");
      chk(upd_cnt == u0, "R5 no update", upd_cnt - u0, 0);
      do_load();
      chk_lanes("R5 staging untouched");
    end

    // R6 flow-through with both strobes low
    ld_n = 1'b0;
    wait_n(3);
    addr = 2'd2; wr_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      data = 8'(8'hA0 + i * 7);
      wait_n(4);
      chk(dac[23:16] == data, "R6 follows bus", dac[23:16], data);
      chk(dac[7:0] == exp_in[0] && dac[31:24] == exp_in[3], "R6 others",
          {dac[31:24], dac[7:0]}, {exp_in[3], exp_in[0]});
    end
    wr_n = 1'b1;
    wait_n(HOLD + 4);
    ld_n = 1'b1;
    wait_n(4);
    exp_in[2] = data;
    for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
    chk(err_cnt == 0, "R8 safe release", err_cnt, 0);
    chk_lanes("R6 final");

    // R8 hold window sweep
    hold_case(0, 8'h5A, 1);
    hold_case(3, 8'hC3, 1);
    hold_case(HOLD - 1, 8'h7E, 1);
    hold_case(HOLD, 8'h81, 0);
    hold_case(HOLD + 8, 8'h18, 0);
    begin
      int e0;
      e0 = err_cnt;
      do_write(2'd3, 8'h99);
      do_load();
      chk(err_cnt == e0, "R8 plain load", err_cnt - e0, 0);
      chk_lanes("R8 plain load codes");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule